// File: doc/BRIEF.md
# Latched Universal Seven-Segment Decoder

This block takes a four-bit BCD digit, keeps it in a data register, and converts it to seven segment lines. Every segment line then passes through an exclusive-OR with a single polarity signal. Tying that signal low gives active-high segments for a common-cathode LED. Tying it high gives active-low segments for a common-anode LED. Driving it with a slow square wave gives the AC segment drive a liquid-crystal panel needs. The polarity signal also appears on a backplane output, so an LCD's common plate is driven in step with the segments.

The data register is transparent while the active-low hold control is high: it reloads from the BCD input on every clock edge. While the control is low, the register keeps the value sampled at the last edge before the control fell. An active-high blank input turns every segment off whatever digit is held. "Off" always means the segment line equals the polarity signal.

A parameter selects where the polarity comes from: the external pin, or an internal divider that makes a 50% duty square wave from the system clock.

Top module: `uni_seg_decoder`

## Requirements
- R1: On a clock edge where `hold_n` is high, the register loads `digit_in`. From just after that edge, `seg_out` shows the decode of that digit.
- R2: On edges where `hold_n` is low, the register keeps its value. With `blank_in` and the polarity unchanged, `seg_out` stays the same whatever `digit_in` does.
- R3: While `blank_in` is 1, every bit of `seg_out` equals the polarity in use, and the held digit has no effect. The held digit reappears when `blank_in` returns to 0.
- R4: `seg_out` is the lit pattern XOR the polarity replicated on all seven bits. Polarity 0 gives a lit segment as 1, and polarity 1 gives a lit segment as 0.
- R5: Bit order is `seg_out[0]`=a, `[1]`=b, `[2]`=c, `[3]`=d, `[4]`=e, `[5]`=f, `[6]`=g. The lit patterns (g..a, hex) for digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R6: Codes 10 to 15 light no segment, so `seg_out` equals the polarity on all bits.
- R7: `bplane_out` always equals the polarity in use. With `INT_PHASE`=0 that polarity is `phase_in`.
- R8: With `INT_PHASE`=1 the polarity comes from the internal divider and `phase_in` has no effect. The divider output is 0 after reset and toggles every `HALF_PERIOD` clock edges, so after the k-th edge since reset release it equals floor(k/`HALF_PERIOD`) mod 2.
- R9: During reset the register holds digit 0 and the internal polarity is 0. With `blank_in`=0 and polarity 0, `seg_out` reads 3F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| digit_in | input | 4 | BCD digit to display |
| hold_n | input | 1 | High: register reloads every edge. Low: register holds |
| phase_in | input | 1 | External polarity (used when INT_PHASE=0) |
| blank_in | input | 1 | Active-high blanking of all segments |
| seg_out | output | 7 | Segment lines a..g after polarity XOR |
| bplane_out | output | 1 | Polarity in use, for a display backplane |

## Verification
If the held digit is wrong, `seg_out` is wrong from the first sampling point after the clock edge that stored it. If the hold control is ignored, `seg_out` changes within one cycle of new input while the display should be frozen. A wrong state in the internal divider shows on `bplane_out` at the edge where a toggle is missed or comes early, and every segment line shows the same error at that moment. Blanking and polarity are combinational from the register and polarity, so errors there appear in the same cycle as the input that exposes them.

// File: rtl/useg_pkg.sv
package useg_pkg;
  localparam int DIGIT_W = 4;
  localparam int SEG_W   = 7;

  typedef logic [SEG_W-1:0]   seg_t;
  typedef logic [DIGIT_W-1:0] digit_t;

  // Lit pattern, bit 0 = segment a ... bit 6 = segment g; codes above 9 dark
  function automatic seg_t digit_to_lit(input digit_t d);
    seg_t r;
    case (d)
      4'd0:    r = 7'h3F;
      4'd1:    r = 7'h06;
      4'd2:    r = 7'h5B;
      4'd3:    r = 7'h4F;
      4'd4:    r = 7'h66;
      4'd5:    r = 7'h6D;
      4'd6:    r = 7'h7D;
      4'd7:    r = 7'h07;
      4'd8:    r = 7'h7F;
      4'd9:    r = 7'h6F;
      default: r = 7'h00;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/useg_hold_reg.sv
module useg_hold_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/useg_phase_gen.sv
module useg_phase_gen #(
  parameter int HALF_PERIOD = 1250000
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase
);
  localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          ph_nxt;
  logic          wrap;

  always_comb begin
    wrap    = (cnt_q == LAST);
    cnt_nxt = wrap ? '0 : cnt_q + 1'b1;
    ph_nxt  = wrap ? ~phase : phase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      phase <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      phase <= ph_nxt;
    end
  end
endmodule

// File: rtl/useg_out_stage.sv
module useg_out_stage
  import useg_pkg::*;
(
  input  digit_t code,
  input  logic   blank,
  input  logic   phase,
  output seg_t   seg
);
  seg_t lit;

  always_comb begin
    lit = blank ? '0 : digit_to_lit(code);
  end

  for (genvar i = 0; i < SEG_W; i++) begin : g_pol
    assign seg[i] = lit[i] ^ phase;
  end
endmodule

// File: rtl/uni_seg_decoder.sv
module uni_seg_decoder
  import useg_pkg::*;
#(
  parameter bit INT_PHASE   = 1'b0,
  parameter int HALF_PERIOD = 1250000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   digit_in,
  input  logic         hold_n,
  input  logic         phase_in,
  input  logic         blank_in,
  output logic [6:0]   seg_out,
  output logic         bplane_out
);
  digit_t held_q;
  logic   pol;

  useg_hold_reg #(.W(DIGIT_W)) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .load (hold_n),
    .d    (digit_in),
    .q    (held_q)
  );

  if (INT_PHASE) begin : g_int_phase
    useg_phase_gen #(.HALF_PERIOD(HALF_PERIOD)) u_pgen (
      .clk  (clk),
      .rst_n(rst_n),
      .phase(pol)
    );
  end else begin : g_ext_phase
    assign pol = phase_in;
  end

  useg_out_stage u_out (
    .code (held_q),
    .blank(blank_in),
    .phase(pol),
    .seg  (seg_out)
  );

  assign bplane_out = pol;
endmodule

// File: rtl/useg_checker.sv
module useg_checker #(
  parameter bit INT_PHASE   = 1'b0,
  parameter int HALF_PERIOD = 1250000
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] digit_in,
  input logic       hold_n,
  input logic       phase_in,
  input logic       blank_in,
  input logic [6:0] seg_out,
  input logic       bplane_out
);
  assert_blank_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    blank_in |-> seg_out == {7{bplane_out}});

  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(hold_n) && $past(blank_in) == blank_in && $past(bplane_out) == bplane_out)
      |-> seg_out == $past(seg_out));

  assert_dark_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(hold_n) && $past(digit_in) > 4'd9)
      |-> seg_out == {7{bplane_out}});

  assert_zero_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(hold_n) && $past(digit_in) == 4'd0 && !blank_in)
      |-> seg_out == (7'h3F ^ {7{bplane_out}}));

  if (INT_PHASE) begin : g_int_chk
    localparam int RW = $clog2(HALF_PERIOD + 2) + 1;
    logic [RW-1:0] run_q;
    logic          prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_q  <= '0;
        prev_q <= 1'b0;
      end else begin
        prev_q <= bplane_out;
        run_q  <= (bplane_out != prev_q) ? '0 : run_q + 1'b1;
      end
    end

    assert_phase_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= RW'(HALF_PERIOD));
  end else begin : g_ext_chk
    assert_bplane_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bplane_out == phase_in);
  end
endmodule

bind uni_seg_decoder useg_checker #(
  .INT_PHASE  (INT_PHASE),
  .HALF_PERIOD(HALF_PERIOD)
) u_useg_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .digit_in  (digit_in),
  .hold_n    (hold_n),
  .phase_in  (phase_in),
  .blank_in  (blank_in),
  .seg_out   (seg_out),
  .bplane_out(bplane_out)
);

// File: tb/test_uni_seg_decoder.sv
module test_uni_seg_decoder;
  localparam int LCD_HALF = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] digit_in;
  logic       hold_n;
  logic       phase_in;
  logic       blank_in;
  logic [6:0] seg_out, seg_lcd;
  logic       bplane_out, bplane_lcd;

  int checks = 0;
  int failures = 0;
  int edges = 0;
  bit done = 0;

  typedef struct {
    logic [6:0] seg_exp;
    logic [6:0] lit;
    logic       pol;
    string      tag;
  } item_t;

  item_t      sb[$];
  logic [3:0] m_held;

  always #4 clk = ~clk;

  uni_seg_decoder i_uni_seg_decoder (
    .clk(clk), .rst_n(rst_n), .digit_in(digit_in), .hold_n(hold_n),
    .phase_in(phase_in), .blank_in(blank_in),
    .seg_out(seg_out), .bplane_out(bplane_out)
  );

  uni_seg_decoder #(.INT_PHASE(1'b1), .HALF_PERIOD(LCD_HALF)) i_uni_seg_decoder_lcd (
    .clk(clk), .rst_n(rst_n), .digit_in(digit_in), .hold_n(hold_n),
    .phase_in(phase_in), .blank_in(blank_in),
    .seg_out(seg_lcd), .bplane_out(bplane_lcd)
  );

  function automatic logic [6:0] lit_of(input logic [3:0] d);
    case (d)
      4'd0: return 7'h3F;  4'd1: return 7'h06;  4'd2: return 7'h5B;
      4'd3: return 7'h4F;  4'd4: return 7'h66;  4'd5: return 7'h6D;
      4'd6: return 7'h7D;  4'd7: return 7'h07;  4'd8: return 7'h7F;
      4'd9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [3:0] d, input logic ln, input logic bl,
                      input logic ph, input string tag);
    item_t it;
    @(negedge clk);
    digit_in = d; hold_n = ln; blank_in = bl; phase_in = ph;
    if (ln) m_held = d;
    it.lit     = bl ? 7'h00 : lit_of(m_held);
    it.pol     = ph;
    it.seg_exp = it.lit ^ {7{ph}};
    it.tag     = tag;
    sb.push_back(it);
  endtask

  // Monitor: samples 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n) edges++;
      #2;
      if (sb.size() > 0) begin
        item_t it;
        logic  exp_ph;
        it = sb.pop_front();
        exp_ph = ((edges / LCD_HALF) % 2) == 1;
        check(it.tag, seg_out, it.seg_exp);
        check("R7 bplane ext", {6'd0, bplane_out}, {6'd0, it.pol});
        check("R8 bplane int", {6'd0, bplane_lcd}, {6'd0, exp_ph});
        check({it.tag, " R8 lcd"}, seg_lcd, it.lit ^ {7{exp_ph}});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; digit_in = 4'd5; hold_n = 1'b1; blank_in = 1'b0; phase_in = 1'b0;
    m_held = 4'd0;
    repeat (3) @(negedge clk);
    check("R9 reset seg", seg_out, 7'h3F);
    check("R9 reset lcd seg", seg_lcd, 7'h3F);
    check("R9 reset bplane", {6'd0, bplane_lcd}, 7'd0);
    rst_n = 1'b1;

    // R1 R5 R6: transparent decode, both polarities (R4)
    for (int i = 0; i < 16; i++) step(4'(i), 1'b1, 1'b0, 1'b0, (i > 9) ? "R6" : "R5");
    for (int i = 0; i < 16; i++) step(4'(i), 1'b1, 1'b0, 1'b1, "R4");

    // R2: capture then hold while input changes
    step(4'd7, 1'b1, 1'b0, 1'b0, "R1");
    step(4'd3, 1'b0, 1'b0, 1'b0, "R2");
    step(4'd9, 1'b0, 1'b0, 1'b0, "R2");
    step(4'd12, 1'b0, 1'b0, 1'b1, "R2");
    // R3: blank while held, then unblank shows held digit
    step(4'd1, 1'b0, 1'b1, 1'b0, "R3");
    step(4'd1, 1'b0, 1'b1, 1'b1, "R3");
    step(4'd1, 1'b0, 1'b0, 1'b0, "R3");
    step(4'd4, 1'b1, 1'b0, 1'b0, "R1");
    // Capture point: last edge with control high
    step(4'd2, 1'b1, 1'b0, 1'b0, "R1");
    step(4'd8, 1'b0, 1'b0, 1'b0, "R2");
    step(4'd8, 1'b0, 1'b0, 1'b1, "R2");

    // Mixed pattern
    for (int i = 0; i < 60; i++)
      step(4'(i % 11), (i % 3) != 0, (i % 7) == 0, ((i >> 1) & 1) == 1, "R4");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule